// File: doc/BRIEF.md
# Shared USB/UART Port Controller

This block is the digital front end for one data-line pair on a connector that carries either full-speed USB or a plain UART link. A bus-power sense input is synchronized and debounced. Together with a logic-supply-good input it selects one of three operating modes: USB, UART or off. In each mode the block decides which of its two modelled pads (positive and negative line) it drives and from where.

In USB mode the host-side single-ended lines either drive the pads directly or mirror them back. A differential receive bit follows the pair, holds its value through single-ended-zero and equal-high states, and reads low while suspend is requested. In UART mode the positive pad is a receive input and the negative pad carries the transmit line. In off mode both pads float and every control is ignored. Each mode change floats both pads for one cycle before the new direction takes effect. The positive-line pull-up is granted only in USB mode with the attach request set.

Each pad is modelled as three digital signals: an output enable, a drive value and the sampled line value.

Top module: `shared_port_ctrl`

## Requirements
- R1: `busDetect` rises or falls only after the synchronized bus-power sense has held its new value for DEBOUNCE_CYCLES consecutive clocks. A pulse shorter than that leaves `busDetect` and the mode unchanged.
- R2: The mode is off while `logicOk` is low. Otherwise it is USB when `busDetect` is high and UART when `busDetect` is low.
- R3: In USB mode with `recvSel`=0, both pads are enabled, `dpDo` equals `vpIn` and `dmDo` equals `vmIn`. With `vpIn`=`vmIn`=0, both pads drive 0 (single-ended zero).
- R4: In USB mode with `recvSel`=1, both pad enables are low, `vpOut` equals `dpDi` and `vmOut` equals `dmDi`.
- R5: In USB mode without suspend, `rcvOut` becomes 1 one clock after the pads read (dp=1, dm=0) and 0 one clock after they read (dp=0, dm=1). It keeps its value when they read (0,0) or (1,1). It behaves the same with `recvSel` at 0 or 1.
- R6: In USB mode with `suspendReq`=1, `rcvOut` is 0 and the stored receive bit is not updated; on release it shows the value stored before suspend. `vpOut`/`vmOut` keep mirroring the pads, and the transmit path of R3 still drives.
- R7: In UART mode `dpOe`=0, `dmOe`=1, `dmDo` equals `uartTx` and `uartRx` equals `dpDi`, whatever `recvSel` and `attachReq` are. Outside UART mode `uartRx` is 1.
- R8: `pullupEn` is 1 exactly when the mode is USB and `attachReq` is 1.
- R9: In off mode both pad enables, `pullupEn`, `vpOut` and `vmOut` are 0, whatever `recvSel`, `vpIn`, `vmIn`, `attachReq` and `suspendReq` are.
- R10: On every mode change both pad enables are low for exactly one clock before the new mode's drive pattern appears.
- R11: During reset and after it, until the first debounce evaluation completes, the mode is off: both pad enables are 0, `busDetect` is 0 and `rcvOut` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busPowerIn | input | 1 | Raw bus-power sense, asynchronous |
| logicOk | input | 1 | Logic-supply-good, synchronous |
| recvSel | input | 1 | USB direction: 0 = host drives pads, 1 = pads mirrored to host |
| suspendReq | input | 1 | USB suspend request |
| attachReq | input | 1 | Request for the positive-line pull-up |
| vpIn | input | 1 | Host positive-line transmit value |
| vmIn | input | 1 | Host negative-line transmit value |
| vpOut | output | 1 | Mirrored positive-line value |
| vmOut | output | 1 | Mirrored negative-line value |
| rcvOut | output | 1 | Differential receive bit |
| uartTx | input | 1 | UART transmit line from the host |
| uartRx | output | 1 | UART receive line to the host |
| busDetect | output | 1 | Debounced bus-power present |
| pullupEn | output | 1 | Positive-line pull-up enable |
| dpOe | output | 1 | Positive pad output enable |
| dpDo | output | 1 | Positive pad drive value |
| dpDi | input | 1 | Positive pad sampled line |
| dmOe | output | 1 | Negative pad output enable |
| dmDo | output | 1 | Negative pad drive value |
| dmDi | input | 1 | Negative pad sampled line |

## Verification
The bench builds the block with DEBOUNCE_CYCLES=8 and SYNC_STAGES=2. The short window lets it check a pulse of half the window being rejected and a held level being accepted, with several full mode changes in a short run. The one-cycle float on UART-to-USB and USB-to-UART changes is counted cycle by cycle. The bench pad model loops driven values back onto the sampled line, so the receive bit can be shown to follow the pads while the block is transmitting.

// File: rtl/shared_port_pkg.sv
package shared_port_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_USB  = 2'd1,
    MODE_UART = 2'd2
  } portMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic usbOn;        // USB mode active
    logic uartOn;       // UART mode active
    logic txDrive;      // USB host drives both pads
    logic uartDrive;    // negative pad carries UART transmit
    logic seRx;         // single-ended mirrors active
    logic rcvEn;        // differential receive bit may update
    logic rcvForceLow;  // suspend forces receive bit low
  } pathCtl_t;

endpackage

// File: rtl/bus_sense_filter.sv
module bus_sense_filter #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic stableOut,
  output logic evalDone
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic syncOut;
  logic prevSample;
  logic [CNT_W-1:0] runCnt;
  logic holdOk;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else if (i == 0) syncChain[i] <= rawIn;
        else syncChain[i] <= syncChain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_STAGES-1];
  assign holdOk  = (runCnt == CNT_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= 1'b0;
      runCnt     <= '0;
      stableOut  <= 1'b0;
      evalDone   <= 1'b0;
    end else begin
      prevSample <= syncOut;
      if (syncOut != prevSample) runCnt <= '0;
      else if (!holdOk) runCnt <= runCnt + 1'b1;
      if (holdOk) begin
        stableOut <= prevSample;
        evalDone  <= 1'b1;
      end
    end
  end

  // R1: the filtered level moves only after a full stable window
  p_debounce_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stableOut != $past(stableOut)) |-> ($past(runCnt) == CNT_TOP));

endmodule

// File: rtl/port_mode_ctrl.sv
module port_mode_ctrl
  import shared_port_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     busStable,
  input  logic     evalDone,
  input  logic     logicOk,
  input  logic     recvSel,
  input  logic     suspendReq,
  input  logic     attachReq,
  output pathCtl_t ctl,
  output logic     busDetect,
  output logic     pullupEn
);
  portMode_e curMode, nextMode;
  logic      gapCycle;

  assign busDetect = busStable & evalDone;

  always_comb begin
    if (!evalDone || !logicOk) nextMode = MODE_OFF;
    else if (busStable)        nextMode = MODE_USB;
    else                       nextMode = MODE_UART;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode  <= MODE_OFF;
      gapCycle <= 1'b0;
    end else begin
      curMode  <= nextMode;
      gapCycle <= (nextMode != curMode);
    end
  end

  always_comb begin
    ctl.usbOn       = (curMode == MODE_USB);
    ctl.uartOn      = (curMode == MODE_UART);
    ctl.txDrive     = ctl.usbOn & ~recvSel & ~gapCycle;
    ctl.uartDrive   = ctl.uartOn & ~gapCycle;
    ctl.seRx        = ctl.usbOn & recvSel;
    ctl.rcvEn       = ctl.usbOn & ~suspendReq;
    ctl.rcvForceLow = ctl.usbOn & suspendReq;
  end

  assign pullupEn = ctl.usbOn & attachReq;

  // R10: every change of mode opens a float cycle
  p_gap_on_change_r10: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != $past(curMode)) |-> gapCycle);

  // R2: USB mode only follows a detected, supplied bus
  p_usb_follows_bus_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_USB) |-> $past(busStable && evalDone && logicOk));

  // R11: nothing but off before the first evaluation
  p_off_before_eval_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(evalDone) |-> (curMode == MODE_OFF));

endmodule

// File: rtl/port_pad_path.sv
module port_pad_path
  import shared_port_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  pathCtl_t ctl,
  input  logic     vpIn,
  input  logic     vmIn,
  input  logic     uartTx,
  input  logic     dpDi,
  input  logic     dmDi,
  output logic     vpOut,
  output logic     vmOut,
  output logic     rcvOut,
  output logic     uartRx,
  output logic     dpOe,
  output logic     dpDo,
  output logic     dmOe,
  output logic     dmDo
);
  logic rcvHold;

  always_comb begin
    dpOe = ctl.txDrive;
    dmOe = ctl.txDrive | ctl.uartDrive;
    dpDo = ctl.txDrive & vpIn;
    if (ctl.txDrive)        dmDo = vmIn;
    else if (ctl.uartDrive) dmDo = uartTx;
    else                    dmDo = 1'b0;
  end

  assign vpOut  = ctl.seRx & dpDi;
  assign vmOut  = ctl.seRx & dmDi;
  assign uartRx = ctl.uartOn ? dpDi : 1'b1;

  // differential receive bit: J/K update, SE0 and equal-high hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rcvHold <= 1'b1;
    else if (ctl.rcvEn) begin
      if (dpDi && !dmDi)      rcvHold <= 1'b1;
      else if (!dpDi && dmDi) rcvHold <= 1'b0;
    end
  end

  assign rcvOut = ctl.rcvForceLow ? 1'b0 : rcvHold;

  // R5: single-ended zero keeps the receive bit
  p_rcv_hold_se0_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rcvEn && !dpDi && !dmDi) |=> (rcvHold == $past(rcvHold)));

  // R5: a J state is captured on the next edge
  p_rcv_track_j_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rcvEn && dpDi && !dmDi) |=> rcvHold);

  // R6: suspend freezes the stored bit
  p_rcv_frozen_sus_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rcvForceLow |=> (rcvHold == $past(rcvHold)));

  // R9: no pad driven outside USB and UART modes
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.usbOn && !ctl.uartOn) |-> (!dpOe && !dmOe));

  // R7: UART never drives the positive pad
  p_uart_dp_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.uartOn |-> !dpOe);

endmodule

// File: rtl/shared_port_ctrl.sv
module shared_port_ctrl
  import shared_port_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic busPowerIn,
  input  logic logicOk,
  input  logic recvSel,
  input  logic suspendReq,
  input  logic attachReq,
  input  logic vpIn,
  input  logic vmIn,
  output logic vpOut,
  output logic vmOut,
  output logic rcvOut,
  input  logic uartTx,
  output logic uartRx,
  output logic busDetect,
  output logic pullupEn,
  output logic dpOe,
  output logic dpDo,
  input  logic dpDi,
  output logic dmOe,
  output logic dmDo,
  input  logic dmDi
);
  logic     busStable;
  logic     evalDone;
  pathCtl_t ctl;

  bus_sense_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) u_filter (
    .clk(clk), .rstN(rstN), .rawIn(busPowerIn),
    .stableOut(busStable), .evalDone(evalDone)
  );

  port_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busStable(busStable), .evalDone(evalDone),
    .logicOk(logicOk), .recvSel(recvSel), .suspendReq(suspendReq),
    .attachReq(attachReq), .ctl(ctl), .busDetect(busDetect),
    .pullupEn(pullupEn)
  );

  port_pad_path u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vpIn(vpIn), .vmIn(vmIn),
    .uartTx(uartTx), .dpDi(dpDi), .dmDi(dmDi), .vpOut(vpOut),
    .vmOut(vmOut), .rcvOut(rcvOut), .uartRx(uartRx), .dpOe(dpOe),
    .dpDo(dpDo), .dmOe(dmOe), .dmDo(dmDo)
  );

  // R8: pull-up never granted without a detected bus
  p_pullup_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    pullupEn |-> $past(busDetect));

endmodule

// File: tb/shared_port_ctrl_bench.sv
`timescale 1ns/1ps
module shared_port_ctrl_bench;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busPowerIn = 1'b0, logicOk = 1'b1, recvSel = 1'b0;
  logic suspendReq = 1'b0, attachReq = 1'b0, vpIn = 1'b0, vmIn = 1'b0;
  logic uartTx = 1'b1, extDp = 1'b0, extDm = 1'b0;
  logic vpOut, vmOut, rcvOut, uartRx, busDetect, pullupEn;
  logic dpOe, dpDo, dpDi, dmOe, dmDo, dmDi;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  // pad model: a driven pad reads back its own value
  assign dpDi = dpOe ? dpDo : extDp;
  assign dmDi = dmOe ? dmDo : extDm;

  shared_port_ctrl #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DB)) u_shared_port_ctrl (
    .clk(clk), .rstN(rstN), .busPowerIn(busPowerIn), .logicOk(logicOk),
    .recvSel(recvSel), .suspendReq(suspendReq), .attachReq(attachReq),
    .vpIn(vpIn), .vmIn(vmIn), .vpOut(vpOut), .vmOut(vmOut), .rcvOut(rcvOut),
    .uartTx(uartTx), .uartRx(uartRx), .busDetect(busDetect),
    .pullupEn(pullupEn), .dpOe(dpOe), .dpDo(dpDo), .dpDi(dpDi),
    .dmOe(dmOe), .dmDo(dmDo), .dmDi(dmDi)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count float cycles until the target drive pattern shows
  task automatic wait_switch(input string tag, input logic wantDp, input logic wantDm);
    int gaps = 0;
    logic seen = 1'b0;
    for (int i = 0; i < 4*DB + 10; i++) begin
      @(negedge clk);
      if (!dpOe && !dmOe) gaps++;
      if (dpOe == wantDp && dmOe == wantDm) begin seen = 1'b1; break; end
    end
    chk({tag, " new pattern reached"}, seen, 1'b1);
    checks++;
    if (gaps != 1) begin
      errors++;
      $display("FAIL R10 %s float cycles act=%0d exp=1", tag, gaps);
    end
  endtask

  task automatic t_reset;
    step(1);
    chk("R11 dpOe in reset", dpOe, 1'b0);
    chk("R11 dmOe in reset", dmOe, 1'b0);
    chk("R11 rcvOut in reset", rcvOut, 1'b1);
    rstN = 1'b1;
    step(2);
    chk("R11 dpOe before eval", dpOe, 1'b0);
    chk("R11 dmOe before eval", dmOe, 1'b0);
    chk("R11 busDetect before eval", busDetect, 1'b0);
    chk("R11 rcvOut idle", rcvOut, 1'b1);
    step(DB + 8);
    chk("R2 UART after eval dmOe", dmOe, 1'b1);
    chk("R2 UART after eval dpOe", dpOe, 1'b0);
  endtask

  task automatic t_uart;
    recvSel = 1'b0; attachReq = 1'b1; vpIn = 1'b1; vmIn = 1'b1;
    uartTx = 1'b0; extDp = 1'b0; step(1);
    chk("R7 dmDo follows tx 0", dmDo, 1'b0);
    chk("R7 uartRx follows dp 0", uartRx, 1'b0);
    chk("R7 dpOe ignores recvSel", dpOe, 1'b0);
    chk("R8 no pullup in UART", pullupEn, 1'b0);
    uartTx = 1'b1; extDp = 1'b1; recvSel = 1'b1; step(1);
    chk("R7 dmDo follows tx 1", dmDo, 1'b1);
    chk("R7 uartRx follows dp 1", uartRx, 1'b1);
    chk("R7 dmOe with recvSel=1", dmOe, 1'b1);
    chk("R4 no mirror in UART", vpOut, 1'b0);
    recvSel = 1'b0; attachReq = 1'b0; vpIn = 1'b0; vmIn = 1'b0;
  endtask

  task automatic t_to_usb;
    busPowerIn = 1'b1; step(DB/2);
    busPowerIn = 1'b0; step(2*DB);
    chk("R1 short pulse busDetect", busDetect, 1'b0);
    chk("R1 short pulse mode kept", dmOe & ~dpOe, 1'b1);
    busPowerIn = 1'b1; step(DB - 1);
    chk("R1 not yet detected", busDetect, 1'b0);
    wait_switch("UART->USB", 1'b1, 1'b1);
    chk("R1 detected", busDetect, 1'b1);
  endtask

  task automatic t_usb_tx;
    for (int k = 0; k < 4; k++) begin
      vpIn = k[1]; vmIn = k[0]; step(1);
      chk("R3 dpDo follows vp", dpDo, logic'(k[1]));
      chk("R3 dmDo follows vm", dmDo, logic'(k[0]));
    end
    vpIn = 1'b0; vmIn = 1'b0; step(1);
    chk("R3 SE0 both enabled", dpOe & dmOe, 1'b1);
    chk("R3 SE0 both low", dpDo | dmDo, 1'b0);
    chk("R7 uartRx idle in USB", uartRx, 1'b1);
    attachReq = 1'b1; step(1);
    chk("R8 pullup on", pullupEn, 1'b1);
    attachReq = 1'b0; step(1);
    chk("R8 pullup off", pullupEn, 1'b0);
    vpIn = 1'b0; vmIn = 1'b1; step(2);
    chk("R5 K while transmitting", rcvOut, 1'b0);
    vpIn = 1'b1; vmIn = 1'b0; step(2);
    chk("R5 J while transmitting", rcvOut, 1'b1);
  endtask

  task automatic t_usb_rx;
    recvSel = 1'b1; extDp = 1'b1; extDm = 1'b0; step(1);
    chk("R4 pads released", dpOe | dmOe, 1'b0);
    step(1);
    chk("R4 vp mirrors dp", vpOut, 1'b1);
    chk("R4 vm mirrors dm", vmOut, 1'b0);
    chk("R5 J gives 1", rcvOut, 1'b1);
    extDp = 1'b0; step(2);
    chk("R4 SE0 visible on vp", vpOut, 1'b0);
    chk("R5 SE0 holds 1", rcvOut, 1'b1);
    extDm = 1'b1; step(1);
    chk("R5 K gives 0", rcvOut, 1'b0);
    chk("R4 vm mirrors dm 1", vmOut, 1'b1);
    extDp = 1'b1; step(2);
    chk("R5 equal-high holds 0", rcvOut, 1'b0);
    extDp = 1'b0; extDm = 1'b0; step(2);
    chk("R5 SE0 holds 0", rcvOut, 1'b0);
  endtask

  task automatic t_suspend;
    extDp = 1'b1; extDm = 1'b0; step(2);
    chk("R5 J before suspend", rcvOut, 1'b1);
    suspendReq = 1'b1; step(1);
    chk("R6 suspend forces low", rcvOut, 1'b0);
    extDp = 1'b0; extDm = 1'b1; step(2);
    chk("R6 vm receiver active", vmOut, 1'b1);
    chk("R6 vp receiver active", vpOut, 1'b0);
    suspendReq = 1'b0; #1;
    chk("R6 stored bit frozen", rcvOut, 1'b1);
    suspendReq = 1'b1; recvSel = 1'b0; vpIn = 1'b1; vmIn = 1'b0; step(1);
    chk("R6 wake-up drive enabled", dpOe & dmOe, 1'b1);
    chk("R6 wake-up drive value", dpDo & ~dmDo, 1'b1);
    suspendReq = 1'b0; step(1);
  endtask

  task automatic t_off;
    logicOk = 1'b0; step(3);
    chk("R2 off pads", dpOe | dmOe, 1'b0);
    chk("R9 off busDetect kept", busDetect, 1'b1);
    recvSel = 1'b1; attachReq = 1'b1; suspendReq = 1'b1; extDp = 1'b1; step(2);
    chk("R9 off ignores controls", dpOe | dmOe, 1'b0);
    chk("R9 off no pullup", pullupEn, 1'b0);
    chk("R9 off no mirror", vpOut, 1'b0);
    recvSel = 1'b0; attachReq = 1'b0; suspendReq = 1'b0; extDp = 1'b0;
    logicOk = 1'b1; step(3);
    chk("R2 back to USB", dpOe & dmOe, 1'b1);
  endtask

  task automatic t_to_uart;
    busPowerIn = 1'b0; step(DB - 1);
    chk("R1 still detected", busDetect, 1'b1);
    wait_switch("USB->UART", 1'b0, 1'b1);
    chk("R2 UART busDetect low", busDetect, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_uart();
    t_to_usb();
    t_usb_tx();
    t_usb_rx();
    t_suspend();
    t_off();
    t_to_uart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule